// File: doc/BRIEF.md
# Skewed-Associative Write-Back Cache

This block is a write-back, write-allocate cache placed between a 32-bit processor port and a 32-bit DRAM port. Every way derives its own set number from the request address: the low index field is rotated left by the way number, and the high index field is kept as is. The stored tag holds the upper address bits together with the high index field. When a dirty line is written back, the controller rebuilds its address by rotating that way's low set bits back to the right.

An access is accepted in the idle state and compared in one cycle against all ways. A hit finishes at once. A miss selects a victim: the lowest-numbered invalid way if one exists, otherwise the way given by an external replacement tracker. If the victim is dirty, its four words are written out first. The requested line is then fetched as four words, and for a write the byte-enabled data is merged into the line while it is filled. Each completed access is reported to the tracker as a one-cycle touch pulse that carries the way number.

Top module: `skew_cache`

## Requirements
- R1: Address fields are: bits [3:2] select the word, A1 = bits [4+LO_W-1:4], A2 = the next HI_W bits, and A3 = the bits above. Way k uses set {A2, A1 rotated left by k}. Lines whose A1 values differ never compete for the same set.
- R2: A read hit returns the addressed word with cpu_rvalid_o high. This happens in the first cycle in which cpu_busy_o is low after acceptance, and it causes no DRAM traffic.
- R3: A write hit updates only the bytes whose cpu_be_i bit is set (bit b covers data bits 8b+7:8b) and marks the line dirty. It causes no DRAM traffic.
- R4: A miss whose victim is clean issues exactly four DRAM reads, at line offsets 0x0, 0x4, 0x8 and 0xC in that order, and no writes. A read miss returns the word that was fetched.
- R5: A miss whose victim is valid and dirty first writes the victim's four words at offsets 0x0 to 0xC in order, then performs the refill of R4.
- R6: The victim is the lowest-numbered invalid way of the request's sets. If every way is valid, the victim is the way given by repl_way_i.
- R7: A write miss refills the line, then merges the enabled bytes into it and leaves the line dirty. A later read returns the merged word.
- R8: The write-back address is {stored tag, low set bits of the victim way rotated right by the way number, offset}. This equals the address the line was filled from.
- R9: cpu_busy_o is high from the cycle after a request is accepted until the access completes. cpu_rvalid_o is high for exactly one cycle.
- R10: After reset no line is valid, cpu_busy_o, cpu_rvalid_o, touch_o and mem_req_o are low.
- R11: While mem_req_o is high and mem_ready_i is low, the DRAM address, direction and write data stay constant.
- R12: Each completed access pulses touch_o for one cycle, with touch_way_o giving the way that was hit or filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Request, sampled while not busy |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W-2 | Word address (byte address bits [ADDR_W-1:2]) |
| cpu_wdata_i | input | 32 | Write data |
| cpu_be_i | input | 4 | Byte enables for writes |
| cpu_busy_o | output | 1 | Access in progress |
| cpu_rvalid_o | output | 1 | Read data valid, one cycle |
| cpu_rdata_o | output | 32 | Read data |
| mem_req_o | output | 1 | DRAM beat request |
| mem_we_o | output | 1 | DRAM beat is a write |
| mem_addr_o | output | ADDR_W | DRAM byte address of the beat |
| mem_wdata_o | output | 32 | DRAM write data |
| mem_ready_i | input | 1 | Beat completes on this edge; read data valid |
| mem_rdata_i | input | 32 | DRAM read data |
| repl_way_i | input | WAY_W | Victim suggested by the replacement tracker |
| touch_o | output | 1 | Access completed |
| touch_way_o | output | WAY_W | Way used by the completed access |

## Verification
The checker examines the port-level timing rules on every cycle. It confirms that DRAM beats are issued only while busy, that a stalled beat holds its values, that offsets advance in 0x4 steps, that a write-back is followed directly by a fetch, and that read-valid and touch pulses are single cycles at completion. Other behaviours depend on stored contents and can only be shown by the bench's scenarios: correct byte merging, victim order, the rebuilt write-back address, and the data that survives a write-back and refill. The bench compares these against a golden memory of its own.

// File: rtl/skc_pkg.sv
package skc_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned LINE_WORDS = 4;
  localparam int unsigned OFF_W      = 4;  // word select + byte offset

  typedef enum logic [1:0] {ST_IDLE, ST_COMP, ST_WB, ST_FETCH} skc_state_e;

  function automatic logic [WORD_W-1:0] be_merge(input logic [WORD_W-1:0] old_w,
                                                 input logic [WORD_W-1:0] new_w,
                                                 input logic [3:0]        be);
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int b = 0; b < 4; b++)
      if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/skc_rot.sv
// Way-specific rotation of the low index field and its inverse.
module skc_rot #(
  parameter int unsigned W = 3,
  parameter int unsigned S = 0
) (
  input  logic [W-1:0] fwd_i,
  output logic [W-1:0] rot_o,
  input  logic [W-1:0] back_i,
  output logic [W-1:0] unrot_o
);
  localparam int unsigned SH = S % W;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      rot_o[(i + SH) % W] = fwd_i[i];
      unrot_o[i]          = back_i[(i + SH) % W];
    end
  end
endmodule

// File: rtl/skc_way_store.sv
module skc_way_store #(
  parameter int unsigned SET_W = 5,
  parameter int unsigned TAG_W = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SET_W-1:0]  set_i,
  input  logic [1:0]        word_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [31:0]       data_o,
  input  logic              data_we_i,
  input  logic [31:0]       data_i,
  input  logic              meta_we_i,
  input  logic [TAG_W-1:0]  meta_tag_i,
  input  logic              meta_dirty_i,
  input  logic              dirty_set_i
);
  localparam int unsigned SETS = 1 << SET_W;

  logic [TAG_W-1:0] tag_q  [SETS];
  logic [31:0]      data_q [SETS*4];
  logic [SETS-1:0]  valid_q, dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (meta_we_i) begin
      valid_q[set_i] <= 1'b1;
      dirty_q[set_i] <= meta_dirty_i;
    end else if (dirty_set_i) begin
      dirty_q[set_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (meta_we_i) tag_q[set_i] <= meta_tag_i;
    if (data_we_i) data_q[{set_i, word_i}] <= data_i;
  end

  assign tag_o   = tag_q[set_i];
  assign valid_o = valid_q[set_i];
  assign dirty_o = dirty_q[set_i];
  assign data_o  = data_q[{set_i, word_i}];
endmodule

// File: rtl/skew_cache.sv
module skew_cache
  import skc_pkg::*;
#(
  parameter int unsigned WAYS   = 4,
  parameter int unsigned LO_W   = 3,
  parameter int unsigned HI_W   = 2,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:2] cpu_addr_i,
  input  logic [31:0]       cpu_wdata_i,
  input  logic [3:0]        cpu_be_i,
  output logic              cpu_busy_o,
  output logic              cpu_rvalid_o,
  output logic [31:0]       cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic [WAY_W-1:0]  repl_way_i,
  output logic              touch_o,
  output logic [WAY_W-1:0]  touch_way_o
);
  localparam int unsigned SET_W = LO_W + HI_W;
  localparam int unsigned TAG_W = ADDR_W - OFF_W - LO_W;  // {A3, A2}

  skc_state_e         state_q;
  logic [ADDR_W-1:2]  addr_q;
  logic               we_q;
  logic [31:0]        wdata_q, rdata_q;
  logic [3:0]         be_q;
  logic [1:0]         beat_q;
  logic [WAY_W-1:0]   vict_q, touch_way_q;
  logic               rvalid_q, touch_q;

  logic [LO_W-1:0]  a1;
  logic [HI_W-1:0]  a2;
  logic [TAG_W-1:0] tag_req;
  logic [1:0]       wsel, word_sel;
  assign a1       = addr_q[OFF_W +: LO_W];
  assign a2       = addr_q[OFF_W+LO_W +: HI_W];
  assign tag_req  = addr_q[ADDR_W-1 -: TAG_W];
  assign wsel     = addr_q[3:2];
  assign word_sel = (state_q == ST_COMP) ? wsel : beat_q;

  logic [TAG_W-1:0] tag_w   [WAYS];
  logic [31:0]      data_w  [WAYS];
  logic [LO_W-1:0]  a1_back [WAYS];
  logic [WAYS-1:0]  valid_w, dirty_w, hit_w, data_we, meta_we, dirty_set;
  logic [31:0]      store_wdata;

  logic beat_done, last_beat;
  assign beat_done = mem_req_o && mem_ready_i;
  assign last_beat = beat_done && (beat_q == 2'd3);

  for (genvar k = 0; k < WAYS; k++) begin : g_way
    logic [LO_W-1:0]  lo_rot;
    logic [SET_W-1:0] set_k;
    skc_rot #(.W(LO_W), .S(k)) u_rot (
      .fwd_i(a1), .rot_o(lo_rot), .back_i(set_k[LO_W-1:0]), .unrot_o(a1_back[k])
    );
    assign set_k = {a2, lo_rot};
    skc_way_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_store (
      .clk_i, .rst_ni,
      .set_i(set_k), .word_i(word_sel),
      .tag_o(tag_w[k]), .valid_o(valid_w[k]), .dirty_o(dirty_w[k]), .data_o(data_w[k]),
      .data_we_i(data_we[k]), .data_i(store_wdata),
      .meta_we_i(meta_we[k]), .meta_tag_i(tag_req), .meta_dirty_i(we_q),
      .dirty_set_i(dirty_set[k])
    );
    assign hit_w[k] = valid_w[k] && (tag_w[k] == tag_req);
  end

  logic             hit_any, found_inv;
  logic [WAY_W-1:0] hit_way, vic_way;
  always_comb begin
    hit_any = 1'b0; hit_way = '0;
    found_inv = 1'b0; vic_way = repl_way_i;
    for (int k = 0; k < WAYS; k++) begin
      if (hit_w[k] && !hit_any) begin hit_any = 1'b1; hit_way = WAY_W'(k); end
      if (!valid_w[k] && !found_inv) begin found_inv = 1'b1; vic_way = WAY_W'(k); end
    end
  end

  logic comp_hit;
  assign comp_hit = (state_q == ST_COMP) && hit_any;

  always_comb begin
    for (int k = 0; k < WAYS; k++) begin
      data_we[k]   = (comp_hit && we_q && hit_way == WAY_W'(k)) ||
                     (state_q == ST_FETCH && beat_done && vict_q == WAY_W'(k));
      meta_we[k]   = (state_q == ST_FETCH) && last_beat && vict_q == WAY_W'(k);
      dirty_set[k] = comp_hit && we_q && hit_way == WAY_W'(k);
    end
    if (state_q == ST_COMP)
      store_wdata = be_merge(data_w[hit_way], wdata_q, be_q);
    else if (we_q && beat_q == wsel)
      store_wdata = be_merge(mem_rdata_i, wdata_q, be_q);
    else
      store_wdata = mem_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; addr_q <= '0; we_q <= 1'b0; wdata_q <= '0; be_q <= '0;
      beat_q <= '0; vict_q <= '0; rdata_q <= '0; rvalid_q <= 1'b0;
      touch_q <= 1'b0; touch_way_q <= '0;
    end else begin
      rvalid_q <= 1'b0;
      touch_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cpu_req_i) begin
          addr_q <= cpu_addr_i; we_q <= cpu_we_i; wdata_q <= cpu_wdata_i; be_q <= cpu_be_i;
          state_q <= ST_COMP;
        end
        ST_COMP: begin
          beat_q <= '0;
          if (hit_any) begin
            rdata_q <= data_w[hit_way];
            rvalid_q <= !we_q;
            touch_q <= 1'b1; touch_way_q <= hit_way;
            state_q <= ST_IDLE;
          end else begin
            vict_q  <= vic_way;
            state_q <= (valid_w[vic_way] && dirty_w[vic_way]) ? ST_WB : ST_FETCH;
          end
        end
        ST_WB: if (beat_done) begin
          beat_q <= beat_q + 2'd1;
          if (beat_q == 2'd3) state_q <= ST_FETCH;
        end
        ST_FETCH: if (beat_done) begin
          beat_q <= beat_q + 2'd1;
          if (beat_q == wsel) rdata_q <= mem_rdata_i;
          if (beat_q == 2'd3) begin
            rvalid_q <= !we_q;
            touch_q <= 1'b1; touch_way_q <= vict_q;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_busy_o   = (state_q != ST_IDLE);
  assign cpu_rvalid_o = rvalid_q;
  assign cpu_rdata_o  = rdata_q;
  assign touch_o      = touch_q;
  assign touch_way_o  = touch_way_q;
  assign mem_req_o    = (state_q == ST_WB) || (state_q == ST_FETCH);
  assign mem_we_o     = (state_q == ST_WB);
  assign mem_wdata_o  = data_w[vict_q];
  assign mem_addr_o   = (state_q == ST_WB) ?
                        {tag_w[vict_q], a1_back[vict_q], beat_q, 2'b00} :
                        {addr_q[ADDR_W-1:OFF_W], beat_q, 2'b00};
endmodule

// File: rtl/skc_checker.sv
module skc_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_busy_o,
  input logic              cpu_rvalid_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [31:0]       mem_wdata_o,
  input logic              touch_o
);
  assert_mem_in_access_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> cpu_busy_o);

  assert_rvalid_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rvalid_o |=> !cpu_rvalid_o);

  assert_rvalid_at_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rvalid_o |-> !cpu_busy_o);

  assert_beat_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) &&
       (!mem_we_o || $stable(mem_wdata_o))));

  assert_beat_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && mem_addr_o[3:2] != 2'd3) |=>
      (mem_req_o && mem_addr_o[3:2] == $past(mem_addr_o[3:2]) + 2'd1));

  assert_wb_then_fetch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ready_i && mem_addr_o[3:2] == 2'd3) |=>
      (mem_req_o && !mem_we_o && mem_addr_o[3:2] == 2'd0));

  assert_touch_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_o |-> (!cpu_busy_o ##1 !touch_o));
endmodule

bind skew_cache skc_checker #(.ADDR_W(ADDR_W)) u_skc_checker (.*);

// File: tb/tb_skew_cache.sv
`timescale 1ns/1ps
module tb_skew_cache;
  localparam int WAY_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cpu_req = 0, cpu_we = 0;
  logic [31:2] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic        busy, rvalid, mem_req, mem_we, touch;
  logic [31:0] rdata, mem_addr, mem_wdata;
  logic        mem_ready = 0;
  logic [31:0] mem_rdata = '0;
  logic [WAY_W-1:0] repl_way = '0, touch_way;

  skew_cache dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_be_i(cpu_be),
    .cpu_busy_o(busy), .cpu_rvalid_o(rvalid), .cpu_rdata_o(rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .repl_way_i(repl_way), .touch_o(touch), .touch_way_o(touch_way)
  );

  logic [31:0] dram [0:4095];
  logic [31:0] gold [0:4095];
  logic        log_we   [0:63];
  logic [31:0] log_addr [0:63];
  logic [31:0] log_data [0:63];
  int log_n = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  // DRAM model: ready on every other cycle of a request
  always @(negedge clk) begin
    mem_ready <= mem_req && !mem_ready;
    mem_rdata <= dram[mem_addr[13:2]];
  end
  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (log_n < 64) begin
        log_we[log_n] = mem_we; log_addr[log_n] = mem_addr;
        log_data[log_n] = mem_we ? mem_wdata : mem_rdata;
      end
      log_n++;
      if (mem_we) dram[mem_addr[13:2]] = mem_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  logic [31:0] got_data;
  int          got_tw, cycles, rv_cnt;

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be);
    log_n = 0; got_tw = -1; rv_cnt = 0; cycles = 0; got_data = 'x;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a[31:2]; cpu_wdata = wd; cpu_be = be;
    @(negedge clk);
    cpu_req = 0;
    chk("R9 busy after accept", 32'(busy), 32'd1);
    while (1) begin
      @(negedge clk);
      cycles++;
      if (rvalid) begin rv_cnt++; got_data = rdata; end
      if (touch) got_tw = int'(touch_way);
      if (!busy || cycles > 200) break;
    end
    @(negedge clk);
    if (rvalid) rv_cnt++;
    if (touch) got_tw = -2;
    if (we) gold[a[13:2]] = merge(gold[a[13:2]], wd, be);
  endtask

  task automatic chk_lines(input string req, input int first, input logic we,
                           input logic [31:0] base, input bit chk_data);
    for (int i = 0; i < 4; i++) begin
      chk(req, 32'(log_we[first+i]), 32'(we));
      chk(req, log_addr[first+i], base + 32'(4*i));
      if (chk_data) chk(req, log_data[first+i], gold[(base[13:2]) + 12'(i)]);
    end
  endtask

  task automatic t_reset;
    chk("R10 busy", 32'(busy), 0);
    chk("R10 rvalid", 32'(rvalid), 0);
    chk("R10 mem_req", 32'(mem_req), 0);
    chk("R10 touch", 32'(touch), 0);
  endtask

  task automatic t_cold_read;
    access(0, 32'h0B4, 0, 0);
    chk("R4 read miss data", got_data, gold[32'h0B4 >> 2]);
    chk("R4 beat count", 32'(log_n), 4);
    chk_lines("R4 fetch order", 0, 0, 32'h0B0, 0);
    chk("R6 first invalid way", 32'(got_tw), 0);
    chk("R9 rvalid one cycle", 32'(rv_cnt), 1);
  endtask

  task automatic t_read_hit;
    access(0, 32'h0B4, 0, 0);
    chk("R2 hit data", got_data, gold[32'h0B4 >> 2]);
    chk("R2 no dram", 32'(log_n), 0);
    chk("R9 hit latency", 32'(cycles), 1);
    chk("R12 touch way", 32'(got_tw), 0);
  endtask

  task automatic t_write_hit;
    access(1, 32'h0B4, 32'hDEADBEEF, 4'b0101);
    chk("R3 write hit no dram", 32'(log_n), 0);
    chk("R9 write no rvalid", 32'(rv_cnt), 0);
    access(0, 32'h0B4, 0, 0);
    chk("R3 merged bytes", got_data, gold[32'h0B4 >> 2]);
  endtask

  task automatic t_fill_ways;
    logic [31:0] addrs [3] = '{32'h2B8, 32'h4BC, 32'h6B0};
    logic [31:0] wds   [3] = '{32'h11223344, 32'hA1B2C3D4, 32'h0F0E0D0C};
    logic [3:0]  bes   [3] = '{4'b1111, 4'b1000, 4'b0011};
    for (int i = 0; i < 3; i++) begin
      access(1, addrs[i], wds[i], bes[i]);
      chk("R7 write miss refill only", 32'(log_n), 4);
      chk_lines("R7 refill order", 0, 0, addrs[i] & ~32'hF, 0);
      chk("R6 lowest invalid way", 32'(got_tw), 32'(i + 1));
    end
    for (int i = 0; i < 3; i++) begin
      access(0, addrs[i], 0, 0);
      chk("R7 allocated line hits", 32'(log_n), 0);
      chk("R7 merged after refill", got_data, gold[addrs[i][13:2]]);
    end
  endtask

  task automatic t_dirty_evict;
    repl_way = 2'd2;
    access(0, 32'h8B4, 0, 0);
    chk("R5 wb + fetch beats", 32'(log_n), 8);
    chk_lines("R8 wb address way2", 0, 1, 32'h4B0, 1);
    chk_lines("R5 fetch after wb", 4, 0, 32'h8B0, 0);
    chk("R5 data", got_data, gold[32'h8B4 >> 2]);
    chk("R6 tracker way", 32'(got_tw), 2);
  endtask

  task automatic t_clean_evict;
    repl_way = 2'd2;
    access(0, 32'h4BC, 0, 0);
    chk("R4 clean victim beats", 32'(log_n), 4);
    chk_lines("R4 clean victim reads", 0, 0, 32'h4B0, 0);
    chk("R3 data survived wb", got_data, gold[32'h4BC >> 2]);
  endtask

  task automatic t_evict_way1;
    repl_way = 2'd1;
    access(0, 32'hAB0, 0, 0);
    chk("R5 wb + fetch beats way1", 32'(log_n), 8);
    chk_lines("R8 wb address way1", 0, 1, 32'h2B0, 1);
    chk("R6 tracker way1", 32'(got_tw), 1);
  endtask

  task automatic t_other_set;
    repl_way = 2'd3;
    access(0, 32'h0C0, 0, 0);
    chk("R1 separate set no wb", 32'(log_n), 4);
    chk("R1 invalid way0 in own set", 32'(got_tw), 0);
    access(0, 32'h0B4, 0, 0);
    chk("R1 old line still resident", 32'(log_n), 0);
    chk("R1 old line data", got_data, gold[32'h0B4 >> 2]);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      dram[i] = 32'h5A00_0000 ^ (i * 32'h0001_9E37);
      gold[i] = dram[i];
    end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_cold_read;
    t_read_hit;
    t_write_hit;
    t_fill_ways;
    t_dirty_evict;
    t_clean_evict;
    t_evict_way1;
    t_other_set;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule